// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block walks a two-dimensional pixel surface in raster order and, for every pixel, presents a pair of addresses: the index of the pixel in a packed linear image, and the byte address of that pixel inside a tiled memory layout. A DMA engine uses the pair to tile a linear image or to de-tile a tiled one. It moves the data itself; this block only generates the addresses.

A single start pulse loads the configuration: width and height in pixels, the row pitch in bytes, the pixel size, the tiling layout and an optional XOR swizzle of address bit 6. The block then offers one address pair per cycle under a valid/ready handshake and pulses done after the last pixel. A configuration the block cannot handle raises a one-cycle error pulse, and no addresses are produced for it.

Five layouts are covered: plain linear, a wide 512-byte by 8-row tile, a narrow 128-byte by 32-row tile with 16-byte columns, a 128-byte by 32-row tile built from interleaved 64-byte subtiles, and a 4 KiB tile whose address bits interleave x and y bits. The layouts and the swizzle use shifts and masks only, because every tile dimension is a power of two.

Top module: `tile_addr_gen`

## Requirements
- R1: Pixels are visited with x running fastest, then y. `index_o` starts at 0 for pixel (0,0) and equals y*width + x for each accepted pixel, rising by one per accepted pixel.
- R2: With `tiling_i` = 0 (linear) the address is y*stride + xb. Here xb = x shifted left by `bpp_log_i`, which encodes the pixel size as 0:1, 1:2, 2:4 and 3:8 bytes. No swizzle is applied in this mode.
- R3: With `tiling_i` = 1 (512x8 tiles) the address is (y/8)*stride*8 + (xb/512)*4096 + (y%8)*512 + xb%512, followed by the swizzle of R7.
- R4: With `tiling_i` = 2 (128x32 column tiles) the address is (y/32)*stride*32 + (xb/128)*4096 + ((xb%128)/16)*512 + (y%32)*16 + xb%16, followed by the swizzle of R7.
- R5: With `tiling_i` = 3 (subtile tiles), let cx = (xb%128)/16 and cy = (y%32)/4. The subtile number is (cy/2)*16 + (cx/4)*8 + (cy%2)*4 + cx%4. The address is (y/32)*stride*32 + (xb/128)*4096 + subtile*64 + (y%4)*16 + xb%16, followed by the swizzle of R7.
- R6: With `tiling_i` = 4 (bit-interleaved tiles), address bits 11..0 are, from high to low, xb[6], y[4], xb[5], y[3], xb[4], y[2], y[1:0] and xb[3:0]. Added to these are (xb/128)*4096 and (y/32)*(stride/128)*4096. No swizzle is applied in this mode.
- R7: For tiling codes 1 to 3, `swizzle_i` selects what address bit 6 is XORed with: 0 nothing, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11.
- R8: A start whose tiling code is 5 to 7, whose swizzle code is 5 to 7, or whose width or height is zero raises `err_o` for exactly one cycle on the next cycle. `valid_o` and `done_o` stay low.
- R9: While `valid_o` is high and `ready_i` is low, `valid_o`, `addr_o` and `index_o` hold their values into the next cycle.
- R10: `done_o` is high for exactly one cycle, the cycle after the handshake of pixel (width-1, height-1). `valid_o` is low in that cycle.
- R11: A start while a surface is in progress is ignored, and this includes the cycle of the last handshake. A start while idle, including the cycle in which done is high, is accepted, and pixel (0,0) is valid on the next cycle.
- R12: After reset, `valid_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a surface |
| width_i | input | DIM_W | Surface width in pixels |
| height_i | input | DIM_W | Surface height in rows |
| stride_i | input | STRIDE_W | Row pitch of the tiled surface in bytes |
| bpp_log_i | input | 2 | log2 of bytes per pixel |
| tiling_i | input | 3 | Tiling layout code |
| swizzle_i | input | 3 | Bit-6 swizzle code |
| ready_i | input | 1 | Consumer accepts the current address pair |
| valid_o | output | 1 | Address pair is valid |
| index_o | output | IDX_W | Linear pixel index |
| addr_o | output | ADDR_W | Tiled byte address |
| done_o | output | 1 | One-cycle pulse after the last pixel |
| err_o | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
Two events can fall in the same cycle: the handshake of the final pixel and a new start request. They meet there because the walker is still busy when the last pixel is accepted and goes idle only on the next edge. The bench raises the start input in exactly that cycle. It then checks that done pulses, that no new pixel appears, and that valid stays low afterwards. It also raises start during the done cycle itself and expects pixel (0,0) of the new surface on the following cycle, with index 0 and the computed address.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;

  typedef enum logic [2:0] {
    TM_LINEAR = 3'd0,
    TM_WIDE   = 3'd1,
    TM_COLUMN = 3'd2,
    TM_SUBT   = 3'd3,
    TM_INTLV  = 3'd4
  } tile_mode_e;

  typedef enum logic [2:0] {
    SW_NONE     = 3'd0,
    SW_B9       = 3'd1,
    SW_B9_10    = 3'd2,
    SW_B9_11    = 3'd3,
    SW_B9_10_11 = 3'd4
  } swz_mode_e;

  localparam int unsigned NUM_TILE_MODES = 5;
  localparam int unsigned NUM_SWZ_MODES  = 5;

  // tile geometry, log2
  localparam int unsigned TILE_LG   = 12;
  localparam int unsigned WIDE_C_LG = 9;
  localparam int unsigned WIDE_R_LG = 3;
  localparam int unsigned NARR_C_LG = 7;
  localparam int unsigned NARR_R_LG = 5;
  localparam int unsigned OWORD_LG  = 4;
  localparam int unsigned SUBT_LG   = 6;

  // which of address bits {11,10,9} feed bit 6 for each swizzle code
  function automatic logic [2:0] swz_mask(int unsigned m);
    case (m)
      1:       return 3'b001;
      2:       return 3'b011;
      3:       return 3'b101;
      4:       return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/tag_walker.sv
module tag_walker
  import tile_addr_pkg::*;
#(
  parameter int unsigned DIM_W    = 16,
  parameter int unsigned STRIDE_W = 20,
  parameter int unsigned IDX_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIM_W-1:0]    width_i,
  input  logic [DIM_W-1:0]    height_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [1:0]          bpp_log_i,
  input  logic [2:0]          tiling_i,
  input  logic [2:0]          swizzle_i,
  input  logic                ready_i,
  output logic                busy_o,
  output logic [DIM_W-1:0]    x_o,
  output logic [DIM_W-1:0]    y_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [1:0]          bpp_log_o,
  output tile_mode_e          tiling_o,
  output logic [2:0]          swizzle_o,
  output logic                done_o,
  output logic                err_o
);

  logic                busy_q;
  logic [DIM_W-1:0]    x_q, y_q, width_q, height_q;
  logic [IDX_W-1:0]    idx_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [1:0]          bpp_q;
  tile_mode_e          tiling_q;
  logic [2:0]          swz_q;
  logic                done_q, err_q;

  logic cfg_ok, accept, fire, row_end, last;

  assign cfg_ok  = (32'(tiling_i) < NUM_TILE_MODES) && (32'(swizzle_i) < NUM_SWZ_MODES) &&
                   (width_i != '0) && (height_i != '0);
  assign accept  = start_i && !busy_q;
  assign fire    = busy_q && ready_i;
  assign row_end = (x_q == width_q - DIM_W'(1));
  assign last    = row_end && (y_q == height_q - DIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      idx_q    <= '0;
      width_q  <= '0;
      height_q <= '0;
      stride_q <= '0;
      bpp_q    <= '0;
      tiling_q <= TM_LINEAR;
      swz_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= fire && last;
      err_q  <= accept && !cfg_ok;
      if (accept) begin
        width_q  <= width_i;
        height_q <= height_i;
        stride_q <= stride_i;
        bpp_q    <= bpp_log_i;
        tiling_q <= tile_mode_e'(tiling_i);
        swz_q    <= swizzle_i;
        x_q      <= '0;
        y_q      <= '0;
        idx_q    <= '0;
        busy_q   <= cfg_ok;
      end else if (fire) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) begin
          busy_q <= 1'b0;
        end else if (row_end) begin
          x_q <= '0;
          y_q <= y_q + DIM_W'(1);
        end else begin
          x_q <= x_q + DIM_W'(1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign idx_o     = idx_q;
  assign stride_o  = stride_q;
  assign bpp_log_o = bpp_q;
  assign tiling_o  = tiling_q;
  assign swizzle_o = swz_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/tag_mapper.sv
module tag_mapper
  import tile_addr_pkg::*;
#(
  parameter int unsigned DIM_W    = 16,
  parameter int unsigned STRIDE_W = 20,
  parameter int unsigned ADDR_W   = 32
) (
  input  logic [DIM_W-1:0]    x_i,
  input  logic [DIM_W-1:0]    y_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [1:0]          bpp_log_i,
  input  tile_mode_e          mode_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                swz_en_o
);

  localparam int unsigned XB_W = DIM_W + 3;

  logic [XB_W-1:0]   xb;
  logic [ADDR_W-1:0] xb_a, y_a, str_a;
  logic [ADDR_W-1:0] mul_a, mul_b, prod, row_base, col_base;
  logic [ADDR_W-1:0] in_wide, in_col, in_subt, in_intlv, in_tile;
  logic [2:0]        cx, cy;
  logic [5:0]        subt;
  logic [11:0]       intlv;

  assign xb    = XB_W'(x_i) << bpp_log_i;
  assign xb_a  = ADDR_W'(xb);
  assign y_a   = ADDR_W'(y_i);
  assign str_a = ADDR_W'(stride_i);

  // one shared multiplier: tile-row count times pitch operand
  always_comb begin
    case (mode_i)
      TM_WIDE:                   mul_a = y_a >> WIDE_R_LG;
      TM_COLUMN, TM_SUBT, TM_INTLV: mul_a = y_a >> NARR_R_LG;
      default:                   mul_a = y_a;
    endcase
    mul_b = (mode_i == TM_INTLV) ? (str_a >> NARR_C_LG) : str_a;
  end

  assign prod = mul_a * mul_b;

  always_comb begin
    case (mode_i)
      TM_WIDE:            row_base = prod << WIDE_R_LG;
      TM_COLUMN, TM_SUBT: row_base = prod << NARR_R_LG;
      TM_INTLV:           row_base = prod << TILE_LG;
      default:            row_base = prod;
    endcase
    case (mode_i)
      TM_WIDE: col_base = (xb_a >> WIDE_C_LG) << TILE_LG;
      TM_LINEAR: col_base = '0;
      default: col_base = (xb_a >> NARR_C_LG) << TILE_LG;
    endcase
  end

  // in-tile offsets
  assign in_wide = ((y_a & ADDR_W'(7)) << WIDE_C_LG) | (xb_a & ADDR_W'(511));

  assign in_col  = (((xb_a >> OWORD_LG) & ADDR_W'(7)) << 9) |
                   ((y_a & ADDR_W'(31)) << OWORD_LG) |
                   (xb_a & ADDR_W'(15));

  assign cx   = xb[6:4];
  assign cy   = y_i[4:2];
  assign subt = {cy[2:1], cx[2], cy[0], cx[1:0]};
  assign in_subt = (ADDR_W'(subt) << SUBT_LG) |
                   ((y_a & ADDR_W'(3)) << OWORD_LG) |
                   (xb_a & ADDR_W'(15));

  assign intlv    = {xb[6], y_i[4], xb[5], y_i[3], xb[4], y_i[2], y_i[1:0], xb[3:0]};
  assign in_intlv = ADDR_W'(intlv);

  always_comb begin
    case (mode_i)
      TM_WIDE:   in_tile = in_wide;
      TM_COLUMN: in_tile = in_col;
      TM_SUBT:   in_tile = in_subt;
      TM_INTLV:  in_tile = in_intlv;
      default:   in_tile = xb_a;
    endcase
  end

  assign addr_o   = row_base + col_base + in_tile;
  assign swz_en_o = (mode_i == TM_WIDE) || (mode_i == TM_COLUMN) || (mode_i == TM_SUBT);

endmodule

// File: rtl/tag_swizzle.sv
module tag_swizzle
  import tile_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [2:0]        mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [NUM_SWZ_MODES-1:0] flip;
  logic                     sel;

  for (genvar m = 0; m < NUM_SWZ_MODES; m++) begin : g_src
    localparam logic [2:0] MASK = swz_mask(m);
    assign flip[m] = ^(addr_i[11:9] & MASK);
  end

  always_comb begin
    sel = 1'b0;
    for (int m = 0; m < NUM_SWZ_MODES; m++) begin
      if (32'(mode_i) == m) sel = flip[m];
    end
    sel = sel && en_i;
  end

  assign addr_o = addr_i ^ (ADDR_W'(sel) << 6);

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int unsigned DIM_W    = 16,
  parameter int unsigned STRIDE_W = 20,
  parameter int unsigned IDX_W    = 32,
  parameter int unsigned ADDR_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIM_W-1:0]    width_i,
  input  logic [DIM_W-1:0]    height_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [1:0]          bpp_log_i,
  input  logic [2:0]          tiling_i,
  input  logic [2:0]          swizzle_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    index_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                done_o,
  output logic                err_o
);

  logic [DIM_W-1:0]    x, y;
  logic [STRIDE_W-1:0] stride;
  logic [1:0]          bpp_log;
  tile_mode_e          mode;
  logic [2:0]          swz;
  logic [ADDR_W-1:0]   raw_addr;
  logic                swz_en;

  tag_walker #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .IDX_W(IDX_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .width_i   (width_i),
    .height_i  (height_i),
    .stride_i  (stride_i),
    .bpp_log_i (bpp_log_i),
    .tiling_i  (tiling_i),
    .swizzle_i (swizzle_i),
    .ready_i   (ready_i),
    .busy_o    (valid_o),
    .x_o       (x),
    .y_o       (y),
    .idx_o     (index_o),
    .stride_o  (stride),
    .bpp_log_o (bpp_log),
    .tiling_o  (mode),
    .swizzle_o (swz),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  tag_mapper #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) u_map (
    .x_i       (x),
    .y_i       (y),
    .stride_i  (stride),
    .bpp_log_i (bpp_log),
    .mode_i    (mode),
    .addr_o    (raw_addr),
    .swz_en_o  (swz_en)
  );

  tag_swizzle #(.ADDR_W(ADDR_W)) u_swz (
    .addr_i (raw_addr),
    .en_i   (swz_en),
    .mode_i (swz),
    .addr_o (addr_o)
  );

endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              valid_o,
  input logic [IDX_W-1:0]  index_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic              err_o
);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(index_o)));

  assert_index_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> (!valid_o || (index_o == $past(index_o) + IDX_W'(1))));

  assert_first_index_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (index_o == '0));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!valid_o && !done_o));

  assert_err_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

endmodule

bind tile_addr_gen tile_addr_gen_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .index_o (index_o),
  .addr_o  (addr_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/tile_addr_gen_tb.sv
`timescale 1ns/1ps
module tile_addr_gen_tb;

  localparam int unsigned DIM_W = 16, STRIDE_W = 20, IDX_W = 32, ADDR_W = 32;

  // width, height, stride, bpp_log, tiling, swizzle, stall
  localparam int unsigned VEC [0:7][0:6] = '{
    '{  5,  3,   64, 0, 0, 2, 1},
    '{136,  9, 1024, 2, 1, 0, 0},
    '{136,  9, 1024, 2, 1, 4, 1},
    '{ 40, 33,  256, 2, 2, 1, 0},
    '{ 40, 33,  256, 2, 3, 3, 1},
    '{ 20, 33,  256, 3, 3, 0, 0},
    '{ 40, 33,  256, 2, 4, 2, 1},
    '{ 70,  8,  256, 1, 2, 2, 0}
  };

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [DIM_W-1:0]    width_i = '0, height_i = '0;
  logic [STRIDE_W-1:0] stride_i = '0;
  logic [1:0]          bpp_log_i = '0;
  logic [2:0]          tiling_i = '0, swizzle_i = '0;
  logic                ready_i = 1'b0;
  logic                valid_o, done_o, err_o;
  logic [IDX_W-1:0]    index_o;
  logic [ADDR_W-1:0]   addr_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tile_addr_gen #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .width_i(width_i), .height_i(height_i),
    .stride_i(stride_i), .bpp_log_i(bpp_log_i), .tiling_i(tiling_i), .swizzle_i(swizzle_i),
    .ready_i(ready_i), .valid_o(valid_o), .index_o(index_o), .addr_o(addr_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(int unsigned mode);
    case (mode)
      0: return "R2 linear";
      1: return "R3 wide tile";
      2: return "R4 column tile";
      3: return "R5 subtile";
      default: return "R6 interleave";
    endcase
  endfunction

  function automatic longint model(int unsigned mode, int unsigned swz, int unsigned x,
                                   int unsigned y, int unsigned stride, int unsigned bl);
    longint xb, a, cx, cy, sub, s, b9, b10, b11;
    xb = longint'(x) << bl;
    case (mode)
      0: a = y * stride + xb;
      1: a = (y / 8) * stride * 8 + (xb / 512) * 4096 + (y % 8) * 512 + xb % 512;
      2: a = (y / 32) * stride * 32 + (xb / 128) * 4096 + ((xb % 128) / 16) * 512
             + (y % 32) * 16 + xb % 16;
      3: begin
        cx = (xb % 128) / 16;
        cy = (y % 32) / 4;
        sub = (cy / 2) * 16 + (cx / 4) * 8 + (cy % 2) * 4 + cx % 4;
        a = (y / 32) * stride * 32 + (xb / 128) * 4096 + sub * 64 + (y % 4) * 16 + xb % 16;
      end
      default: a = xb % 16 + (y % 4) * 16 + ((y / 4) % 2) * 64 + ((xb / 16) % 2) * 128
                   + ((y / 8) % 2) * 256 + ((xb / 32) % 2) * 512 + ((y / 16) % 2) * 1024
                   + ((xb / 64) % 2) * 2048 + (xb / 128) * 4096 + (y / 32) * (stride / 128) * 4096;
    endcase
    if (mode >= 1 && mode <= 3) begin
      b9 = (a >> 9) & 1; b10 = (a >> 10) & 1; b11 = (a >> 11) & 1;
      case (swz)
        1: s = b9;
        2: s = b9 ^ b10;
        3: s = b9 ^ b11;
        4: s = b9 ^ b10 ^ b11;
        default: s = 0;
      endcase
      a = a ^ (s << 6); // R7
    end
    return a;
  endfunction

  task automatic drive_start(input int unsigned w, h, st, bl, md, sw);
    start_i = 1'b1; width_i = DIM_W'(w); height_i = DIM_W'(h); stride_i = STRIDE_W'(st);
    bpp_log_i = bl[1:0]; tiling_i = md[2:0]; swizzle_i = sw[2:0];
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_surface(input int unsigned w, h, st, bl, md, sw, stall);
    int unsigned ex = 0, ey = 0, k = 0;
    bit fin = 0, held_v = 0;
    logic [ADDR_W-1:0] held_a;
    logic [IDX_W-1:0]  held_i;
    @(negedge clk); drive_start(w, h, st, bl, md, sw);
    @(negedge clk); start_i = 1'b0;
    check(valid_o && index_o == 0, "R11 first pixel", longint'(index_o), 0);
    while (!fin) begin
      if (held_v)
        check(valid_o && addr_o == held_a && index_o == held_i, "R9 stall hold",
              longint'(addr_o), longint'(held_a));
      ready_i = (stall != 0) ? ((k % 3) != 1) : 1'b1;
      if (ready_i) begin
        held_v = 0;
        check(valid_o && longint'(addr_o) == model(md, sw, ex, ey, st, bl), req_of(md),
              longint'(addr_o), model(md, sw, ex, ey, st, bl));
        check(longint'(index_o) == longint'(ey) * w + ex, "R1 index",
              longint'(index_o), longint'(ey) * w + ex);
        if (ex == w - 1 && ey == h - 1) fin = 1;
        else if (ex == w - 1) begin ex = 0; ey++; end
        else ex++;
      end else begin
        held_v = 1; held_a = addr_o; held_i = index_o;
      end
      @(negedge clk); k++;
    end
    ready_i = 1'b0;
    check(done_o && !valid_o, "R10 done after last", longint'(done_o), 1);
    @(negedge clk);
    check(!done_o, "R10 done single", longint'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(!valid_o && !done_o && !err_o, "R12 reset", longint'({valid_o, done_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!valid_o && !done_o && !err_o, "R12 after release", longint'({valid_o, done_o, err_o}), 0);

    for (int i = 0; i < 8; i++)
      run_surface(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);

    // R8 rejected configurations
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      case (c)
        0: drive_start(4, 4, 64, 0, 5, 0);
        1: drive_start(4, 4, 1024, 0, 1, 6);
        default: drive_start(0, 4, 64, 0, 0, 0);
      endcase
      ready_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      check(err_o && !valid_o && !done_o, "R8 error pulse", longint'(err_o), 1);
      @(negedge clk);
      check(!err_o && !valid_o, "R8 error single, no pixels", longint'({err_o, valid_o}), 0);
    end
    ready_i = 1'b0;

    // R11 start in the last-handshake cycle is ignored
    @(negedge clk); drive_start(2, 1, 16, 0, 0, 0);
    @(negedge clk); start_i = 1'b0; ready_i = 1'b1;
    @(negedge clk); drive_start(3, 3, 16, 0, 0, 0);
    check(valid_o && index_o == 1, "R11 last pixel present", longint'(index_o), 1);
    @(negedge clk); start_i = 1'b0;
    check(done_o && !valid_o, "R10 done with colliding start", longint'(done_o), 1);
    @(negedge clk);
    check(!valid_o && !done_o, "R11 start during last ignored", longint'(valid_o), 0);

    // R11 start in the done cycle is accepted
    @(negedge clk); drive_start(2, 1, 16, 0, 0, 0);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done_o, "R10 done before restart", longint'(done_o), 1);
    drive_start(1, 1, 8, 3, 0, 0);
    @(negedge clk); start_i = 1'b0;
    check(valid_o && index_o == 0 && addr_o == 0, "R11 start in done cycle",
          longint'(addr_o), 0);
    @(negedge clk);
    check(done_o && !valid_o, "R10 single pixel done", longint'(done_o), 1);
    ready_i = 1'b0;

    @(negedge clk);
    summary();
    $finish;
  end

endmodule